// File: doc/BRIEF.md
# UART Receive Buffer and Line Status Unit

This block sits between a UART receiver's deserializer and the host-facing register logic. Each byte the receiver completes arrives with three condition flags: bad parity, missing stop bit and line break. The byte is stored in a first-in first-out queue together with its own flags. The host sees the byte at the head of the queue and removes it with a one-cycle pop strobe. The block also forms an 8-bit line status word. That word reports whether data is waiting, whether a byte was lost to a full queue, the flags of the head byte, a summary of whether any queued byte is flagged, and two transmit-side status bits.

A continuous break on the line produces only one stored break character. Later break completions are dropped until the receive line is seen high again. A byte that completes while the queue is full is thrown away without disturbing the stored entries, and a sticky loss indicator is raised. The host clears that indicator by reading the status word. On the transmit side, the block counts characters in the holding stage from host writes and from transfers to the shift register, and it tracks whether the shift register is busy. The holding stage holds one character in single mode and `TX_DEPTH` characters in queued mode.

Top module: `uart_linestat`

## Requirements
- R1: Status bit 0 is 1 exactly when the receive queue holds at least one byte, and 0 when it is empty.
- R2: The receive queue holds up to `RX_DEPTH` (default 128) bytes. `rd_data` shows the oldest stored byte, and pops return bytes in arrival order.
- R3: A byte that completes while the queue is full, with no pop in the same cycle, is discarded and the stored entries stay unchanged. Status bit 1 then becomes 1 and stays 1 until a cycle in which `stat_rd` is high. A push together with a pop on a full queue is accepted and does not set bit 1.
- R4: Status bit 2 (parity) and bit 3 (framing) equal the flags stored with the head byte. Both are 0 when the queue is empty.
- R5: Status bit 4 equals the break flag of the head byte. Once a break character is stored, further break completions are neither stored nor counted as overrun, until a cycle in which `rx_line` is 1.
- R6: Status bit 7 is 1 while any stored byte carries a parity, framing or break flag, and returns to 0 by itself when the last such byte is popped.
- R7: Status bit 5 is 1 when the transmit holding stage is empty. A host write (`tx_wr`) clears it. A transfer (`tx_xfer`) of the last held character sets it. The stage holds 1 character when `tx_q_mode` is 0 and `TX_DEPTH` characters when it is 1, and writes to a full stage are ignored.
- R8: Status bit 6 is 1 only when the holding stage is empty and the shift register is idle. A transfer makes the shift register busy, and `tx_shift_done` makes it idle again.
- R9: After reset the queue is empty, status reads 8'h60, and a pop on an empty queue changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received byte completed this cycle |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error flag of the byte |
| rx_ferr | input | 1 | Framing error flag of the byte |
| rx_brk | input | 1 | Byte is a break character |
| rx_line | input | 1 | Current receive line level (1 = idle/mark) |
| rd_pop | input | 1 | Remove the head byte |
| rd_data | output | 8 | Head byte of the receive queue |
| stat_rd | input | 1 | Host reads status; clears the overrun bit |
| tx_q_mode | input | 1 | 0: single holding register, 1: queued holding stage |
| tx_wr | input | 1 | Host writes a transmit character |
| tx_xfer | input | 1 | Head held character moves into the shift register |
| tx_shift_done | input | 1 | Shift register finished sending |
| lsr | output | 8 | Line status word |

## Verification
The queue is driven with clean bytes, with bytes carrying a single parity or framing flag in different queue positions, and with a full fill followed by an extra byte and then a push paired with a pop. These patterns separate head-flag reporting from the any-flagged summary, and separate overrun discard from correct wraparound ordering. Break handling is tried with repeated break completions both with and without an intervening high line level, which shows whether duplicate break characters are suppressed. The transmit bits are tried in both holding modes, with writes that go beyond capacity, so that ignored writes and the busy shift register become visible on bits 5 and 6.

// File: rtl/uls_pkg.sv
package uls_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_ent_t;

    localparam int unsigned LS_DR   = 0;
    localparam int unsigned LS_OVR  = 1;
    localparam int unsigned LS_PAR  = 2;
    localparam int unsigned LS_FRM  = 3;
    localparam int unsigned LS_BRK  = 4;
    localparam int unsigned LS_THRE = 5;
    localparam int unsigned LS_TEMT = 6;
    localparam int unsigned LS_ERR  = 7;

endpackage

// File: rtl/uls_rx_fifo.sv
module uls_rx_fifo
    import uls_pkg::*;
#(
    parameter int unsigned DEPTH = 128
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  rx_ent_t wr_ent,
    input  logic    rd_en,
    output rx_ent_t head,
    output logic    empty,
    output logic    ovr_evt,
    output logic    err_any
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic [CW-1:0] ecnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    rx_ent_t  mem_q [DEPTH];

    logic do_push, do_pop, full, flag_in, flag_hd;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        head    = mem_q[st_q.rptr];
        full    = (st_q.cnt == FULLV);
        empty   = (st_q.cnt == '0);
        do_pop  = rd_en && !empty;
        do_push = wr_en && (!full || do_pop);
        ovr_evt = wr_en && full && !do_pop;
        flag_in = wr_ent.perr | wr_ent.ferr | wr_ent.brk;
        flag_hd = head.perr | head.ferr | head.brk;
        err_any = (st_q.ecnt != '0);

        if (do_push) st_d.wptr = ptr_inc(st_q.wptr);
        if (do_pop)  st_d.rptr = ptr_inc(st_q.rptr);
        st_d.cnt  = st_q.cnt + CW'(do_push) - CW'(do_pop);
        st_d.ecnt = st_q.ecnt + CW'(do_push && flag_in) - CW'(do_pop && flag_hd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= wr_ent;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULLV); // R2
    AST_ERRCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ecnt <= st_q.cnt); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> $stable(st_q.wptr)); // R3
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> (st_q.cnt == '0)); // R9

endmodule

// File: rtl/uls_brk_gate.sv
module uls_brk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_brk,
    input  logic line,
    output logic out_valid
);
    typedef struct packed {
        logic hold;
    } brk_st_t;

    brk_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        out_valid = in_valid && !(in_brk && st_q.hold);
        if (out_valid && in_brk) st_d.hold = 1'b1;
        else if (line)           st_d.hold = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_BRK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_brk && out_valid) |=> (in_valid && in_brk && !line) |-> !out_valid); // R5

endmodule

// File: rtl/uls_tx_stat.sv
module uls_tx_stat #(
    parameter int unsigned TX_DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic q_mode,
    input  logic wr,
    input  logic xfer,
    input  logic shift_done,
    output logic thr_empty,
    output logic tx_empty
);
    localparam int unsigned CW = $clog2(TX_DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
    } tx_st_t;

    tx_st_t        st_d, st_q;
    logic [CW-1:0] cap;
    logic          take_wr, take_x;

    always_comb begin
        st_d      = st_q;
        cap       = q_mode ? CW'(TX_DEPTH) : CW'(1);
        take_wr   = wr && (st_q.cnt < cap);
        take_x    = xfer && (st_q.cnt != '0);
        st_d.cnt  = st_q.cnt + CW'(take_wr) - CW'(take_x);
        if (take_x)          st_d.busy = 1'b1;
        else if (shift_done) st_d.busy = 1'b0;
        thr_empty = (st_q.cnt == '0);
        tx_empty  = thr_empty && !st_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TEMT_THRE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty); // R8
    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !xfer) |=> !thr_empty); // R7
    AST_TX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(TX_DEPTH)); // R7

endmodule

// File: rtl/uart_linestat.sv
module uart_linestat
    import uls_pkg::*;
#(
    parameter int unsigned RX_DEPTH = 128,
    parameter int unsigned TX_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       rx_line,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    input  logic       stat_rd,
    input  logic       tx_q_mode,
    input  logic       tx_wr,
    input  logic       tx_xfer,
    input  logic       tx_shift_done,
    output logic [7:0] lsr
);
    typedef struct packed {
        logic ovr;
    } top_st_t;

    top_st_t st_d, st_q;
    rx_ent_t in_ent, head;
    logic    acc_valid, empty, ovr_evt, err_any, thr_empty, tx_empty;

    assign in_ent = '{data: rx_data, perr: rx_perr, ferr: rx_ferr, brk: rx_brk};

    uls_brk_gate u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_brk    (rx_brk),
        .line      (rx_line),
        .out_valid (acc_valid)
    );

    uls_rx_fifo #(.DEPTH(RX_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_valid),
        .wr_ent  (in_ent),
        .rd_en   (rd_pop),
        .head    (head),
        .empty   (empty),
        .ovr_evt (ovr_evt),
        .err_any (err_any)
    );

    uls_tx_stat #(.TX_DEPTH(TX_DEPTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_mode     (tx_q_mode),
        .wr         (tx_wr),
        .xfer       (tx_xfer),
        .shift_done (tx_shift_done),
        .thr_empty  (thr_empty),
        .tx_empty   (tx_empty)
    );

    always_comb begin
        st_d = st_q;
        if (ovr_evt)      st_d.ovr = 1'b1;
        else if (stat_rd) st_d.ovr = 1'b0;

        rd_data         = empty ? 8'h00 : head.data;
        lsr             = '0;
        lsr[LS_DR]      = !empty;
        lsr[LS_OVR]     = st_q.ovr;
        lsr[LS_PAR]     = !empty && head.perr;
        lsr[LS_FRM]     = !empty && head.ferr;
        lsr[LS_BRK]     = !empty && head.brk;
        lsr[LS_THRE]    = thr_empty;
        lsr[LS_TEMT]    = tx_empty;
        lsr[LS_ERR]     = err_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[LS_OVR] && !stat_rd) |=> lsr[LS_OVR]); // R3
    AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !lsr[LS_DR] |-> (lsr[LS_ERR] == 1'b0 && lsr[LS_PAR] == 1'b0)); // R6
    AST_HEAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[LS_PAR] || lsr[LS_FRM] || lsr[LS_BRK]) |-> lsr[LS_ERR]); // R4

endmodule

// File: tb/tb_uart_linestat.sv
module tb_uart_linestat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, rx_line = 1;
    logic [7:0] rx_data = 0;
    logic       rd_pop = 0, stat_rd = 0;
    logic       tx_q_mode = 0, tx_wr = 0, tx_xfer = 0, tx_shift_done = 0;
    logic [7:0] rd_data, lsr;
    int         total = 0, bad = 0;

    always #2.5 clk = ~clk;

    uart_linestat dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_line(rx_line),
        .rd_pop(rd_pop), .rd_data(rd_data), .stat_rd(stat_rd),
        .tx_q_mode(tx_q_mode), .tx_wr(tx_wr), .tx_xfer(tx_xfer),
        .tx_shift_done(tx_shift_done), .lsr(lsr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
        rx_valid = 1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
        @(negedge clk);
        rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
    endtask

    task automatic pop();
        rd_pop = 1; @(negedge clk); rd_pop = 0;
    endtask

    task automatic t_reset();
        check("R9 reset status", lsr, 8'h60);
        pop();
        check("R9 pop on empty", lsr, 8'h60);
        check("R1 empty", {7'd0, lsr[0]}, 8'd0);
    endtask

    task automatic t_order();
        push(8'hA1, 0, 0, 0); push(8'hB2, 0, 0, 0); push(8'hC3, 0, 0, 0);
        check("R1 data ready", {7'd0, lsr[0]}, 8'd1);
        check("R2 head first", rd_data, 8'hA1);
        pop(); check("R2 second", rd_data, 8'hB2);
        pop(); check("R2 third", rd_data, 8'hC3);
        pop(); check("R1 drained", lsr, 8'h60);
    endtask

    task automatic t_flags();
        push(8'h11, 0, 0, 0); push(8'h22, 1, 0, 0); push(8'h33, 0, 0, 0);
        check("R6 summary with clean head", lsr[7:2] & 6'b100111, 6'b100000);
        pop();
        check("R4 parity head", {lsr[7], lsr[4:2]}, 4'b1001);
        pop();
        check("R6 summary cleared", {lsr[7], lsr[4:2]}, 4'b0000);
        pop();
        push(8'h44, 0, 1, 0);
        check("R4 framing head", {lsr[7], lsr[4:2]}, 4'b1010);
        pop();
        check("R6 cleared after framing", lsr, 8'h60);
    endtask

    task automatic t_break();
        rx_line = 0;
        push(8'h00, 0, 1, 1);
        push(8'h00, 0, 1, 1);
        check("R5 break head", {lsr[7], lsr[4], lsr[0]}, 3'b111);
        check("R5 no overrun", {7'd0, lsr[1]}, 8'd0);
        pop();
        check("R5 duplicate not stored", {7'd0, lsr[0]}, 8'd0);
        push(8'h00, 0, 1, 1);
        check("R5 still held", {7'd0, lsr[0]}, 8'd0);
        rx_line = 1; @(negedge clk); rx_line = 0;
        push(8'h00, 0, 1, 1);
        rx_line = 1; @(negedge clk); rx_line = 0;
        push(8'h00, 0, 1, 1);
        rx_line = 1;
        pop();
        check("R5 second break stored", {lsr[4], lsr[0]}, 2'b11);
        pop();
        check("R5 two breaks only", lsr, 8'h60);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 128; i++) push(8'(i), 0, 0, 0);
        check("R2 full no overrun", {lsr[1], lsr[0]}, 2'b01);
        push(8'hEE, 1, 0, 0);
        check("R3 overrun set", {lsr[1], lsr[7]}, 2'b10);
        @(negedge clk);
        check("R3 sticky", {7'd0, lsr[1]}, 8'd1);
        stat_rd = 1; @(negedge clk); stat_rd = 0;
        check("R3 cleared by read", {7'd0, lsr[1]}, 8'd0);
        rd_pop = 1; push(8'h55, 0, 0, 0); rd_pop = 0;
        check("R3 push+pop full no overrun", {7'd0, lsr[1]}, 8'd0);
        for (int i = 1; i < 128; i++) begin
            if (rd_data !== 8'(i)) check("R3 contents intact", rd_data, 8'(i));
            pop();
        end
        check("R2 wrapped tail", rd_data, 8'h55);
        pop();
        check("R2 empty after drain", lsr, 8'h60);
    endtask

    task automatic t_tx();
        tx_q_mode = 0;
        tx_wr = 1; @(negedge clk); @(negedge clk); tx_wr = 0;
        check("R7 write clears", {lsr[6], lsr[5]}, 2'b00);
        tx_xfer = 1; @(negedge clk); tx_xfer = 0;
        check("R7 single mode second write ignored", {lsr[6], lsr[5]}, 2'b01);
        tx_shift_done = 1; @(negedge clk); tx_shift_done = 0;
        check("R8 idle", {lsr[6], lsr[5]}, 2'b11);
        tx_q_mode = 1;
        tx_wr = 1; repeat (17) @(negedge clk); tx_wr = 0;
        tx_xfer = 1; repeat (15) @(negedge clk); tx_xfer = 0;
        check("R7 queued one left", {lsr[6], lsr[5]}, 2'b00);
        tx_xfer = 1; @(negedge clk); tx_xfer = 0;
        check("R7 queued extra write ignored", {lsr[6], lsr[5]}, 2'b01);
        tx_shift_done = 1; @(negedge clk); tx_shift_done = 0;
        check("R8 both empty", {lsr[6], lsr[5]}, 2'b11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_order();
        t_flags();
        t_break();
        t_overrun();
        t_tx();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule